// File: doc/BRIEF.md
# Compare-Match Timer with Overflow Flag

A 16-bit up-counter advances once per count tick. The tick comes from one of three divided system-clock rates or from a slow asynchronous watch clock. The watch clock is brought into the system clock domain by a two-flop synchronizer and then divided by four. The counter is compared against a writable compare register. The block keeps two sticky flags: one for a compare match and one for a wrap from 0xFFFF to 0x0000. Each flag drives its own level interrupt request, gated by an enable bit. As an option, a compare match can return the counter to zero.

A compare match is recognised on the tick that moves the counter off the matching value, not on the tick that brings it there. A power-mode input decides whether the counter runs or freezes. In the low-power states every register keeps its contents. In the sub-clock states only the watch-clock source may drive the counter.

Software reaches four 16-bit registers through a simple write strobe with an address. Read data is combinational from the address. The reset is asynchronous, and its release is synchronised inside the block.

Top module: `cmt_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the compare register reads 0xFFFF, control reads 0, status reads 0, and both interrupt outputs are low.
- R2: The counter advances by exactly one per count tick and holds otherwise. clk_sel 0, 1 and 2 give one tick every 4, 16 and 64 system-clock cycles respectively.
- R3: A tick while the counter is 0xFFFF makes it 0x0000 and sets the overflow flag (status bit 1).
- R4: The match flag (status bit 0) is set by the tick that finds the counter equal to the compare register. Loading or reaching the equal value does not set it by itself.
- R5: With control bit 0 (clear-on-match) set, the match tick loads 0 into the counter instead of incrementing it.
- R6: A write to address 0 loads the counter. It overrides a tick in the same cycle, and that cycle sets neither flag.
- R7: Both flags are sticky. Writing 0 to a flag's status bit clears it, and writing 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R8: irq_match equals the match flag ANDed with control bit 1. irq_ovf equals the overflow flag ANDed with control bit 2.
- R9: clk_sel 3 selects the watch clock. It is sampled by two flops, and one tick is made on every fourth synchronised rising edge.
- R10: pmode 0 (active) and 1 (sleep) run the counter. pmode 2, 3 and 4 (sub-clock states) run it only with clk_sel 3. pmode 5, 6 and 7 halt it. Every register keeps its value whenever the counter is halted.
- R11: The register map is address 0 counter, 1 compare, 2 control (bits 2:0), 3 status (bits 1:0). Unused read bits are 0, and rdata follows addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Asynchronous slow watch clock |
| clk_sel | input | 2 | Count source: 0 /4, 1 /16, 2 /64, 3 watch clock /4 |
| pmode | input | 3 | Power state code |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| irq_match | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
On every cycle the assertions check these counter and flag rules: the single-step increment, the hold when no tick arrives, the wrap and match flag setting, clear-on-match, the priority of a counter load, flag stickiness, and the freeze in halted and badly configured sub-clock states. Only the bench's scenarios can show the behaviour that needs a reference over many cycles. That covers the exact tick rates of each source, the latency of the watch-clock synchronizer, the read map, the interrupt gating, and a flag clear that collides with a set. The bench tracks all of these with a cycle-accurate model under random and directed stimulus.

// File: rtl/cmt_timer_pkg.sv
package cmt_timer_pkg;
  // register addresses
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;
  // control and status bit positions
  localparam int CTL_CLR = 0;
  localparam int CTL_MIE = 1;
  localparam int CTL_OIE = 2;
  localparam int CTL_W   = 3;
  localparam int STS_M   = 0;
  localparam int STS_O   = 1;
  // power states
  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_SUBACT   = 3'd2,
    PM_SUBSLEEP = 3'd3,
    PM_WATCH    = 3'd4,
    PM_STBY     = 3'd5,
    PM_MSTBY    = 3'd6,
    PM_RSVD     = 3'd7
  } pmode_e;
endpackage

// File: rtl/cmt_wclk_sync.sv
module cmt_wclk_sync #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk,
  output logic tick
);
  logic [2:0]       sq_q, sq_nx;
  logic [DIV_W-1:0] div_q, div_nx;
  logic             rise;

  always_comb begin
    sq_nx  = {sq_q[1:0], wclk};
    rise   = sq_q[1] & ~sq_q[2];
    div_nx = rise ? div_q + DIV_W'(1) : div_q;
    tick   = rise & (&div_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q  <= '0;
      div_q <= '0;
    end else begin
      sq_q  <= sq_nx;
      div_q <= div_nx;
    end
  end
endmodule

// File: rtl/cmt_tick_gen.sv
module cmt_tick_gen #(
  parameter int STAGES = 3,
  parameter int STEP   = 2,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [2:0]       pmode,
  output logic             tick
);
  import cmt_timer_pkg::*;
  localparam int PRE_W = STAGES * STEP;
  localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(STAGES);

  logic [PRE_W-1:0]  pre_q, pre_nx;
  logic [STAGES:0]   src_vec;
  logic              wtick, run, sub_state;

  cmt_wclk_sync #(.DIV_W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .wclk (wclk),
    .tick (wtick)
  );

  // one tap per internal rate: all low bits of the prescaler set
  for (genvar g = 0; g < STAGES; g++) begin : g_tap
    assign src_vec[g] = &pre_q[(g+1)*STEP-1:0];
  end
  assign src_vec[STAGES] = wtick;

  always_comb begin
    pre_nx    = pre_q + PRE_W'(1);
    sub_state = (pmode == PM_SUBACT) || (pmode == PM_SUBSLEEP) || (pmode == PM_WATCH);
    run       = (pmode == PM_ACTIVE) || (pmode == PM_SLEEP) ||
                (sub_state && (clk_sel == SEL_EXT));
    tick      = run & src_vec[clk_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nx;
  end
endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          we,
  input  logic [1:0]                    addr,
  input  logic [CNT_W-1:0]              wdata,
  output logic [CNT_W-1:0]              cnt,
  output logic [CNT_W-1:0]              cmp,
  output logic [cmt_timer_pkg::CTL_W-1:0] ctl,
  output logic                          flag_m,
  output logic                          flag_o
);
  import cmt_timer_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_nx, cmp_q, cmp_nx;
  logic [CTL_W-1:0] ctl_q, ctl_nx;
  logic             fm_q, fm_nx, fo_q, fo_nx;
  logic             cnt_wr, sts_wr, hit, match_ev, ovf_ev;

  always_comb begin
    cnt_wr   = we && (addr == A_CNT);
    sts_wr   = we && (addr == A_STS);
    hit      = (cnt_q == cmp_q);
    match_ev = tick && !cnt_wr && hit;
    ovf_ev   = tick && !cnt_wr && (&cnt_q);

    cnt_nx = cnt_q;
    if (cnt_wr)    cnt_nx = wdata;
    else if (tick) cnt_nx = (hit && ctl_q[CTL_CLR]) ? '0 : cnt_q + CNT_W'(1);

    cmp_nx = (we && (addr == A_CMP)) ? wdata : cmp_q;
    ctl_nx = (we && (addr == A_CTL)) ? wdata[CTL_W-1:0] : ctl_q;

    fm_nx = fm_q;
    if (match_ev)                    fm_nx = 1'b1;
    else if (sts_wr && !wdata[STS_M]) fm_nx = 1'b0;
    fo_nx = fo_q;
    if (ovf_ev)                      fo_nx = 1'b1;
    else if (sts_wr && !wdata[STS_O]) fo_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '1;
      ctl_q <= '0;
      fm_q  <= 1'b0;
      fo_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      cmp_q <= cmp_nx;
      ctl_q <= ctl_nx;
      fm_q  <= fm_nx;
      fo_q  <= fo_nx;
    end
  end

  assign cnt    = cnt_q;
  assign cmp    = cmp_q;
  assign ctl    = ctl_q;
  assign flag_m = fm_q;
  assign flag_o = fo_q;
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic [1:0]       clk_sel,
  input  logic [2:0]       pmode,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_match,
  output logic             irq_ovf
);
  import cmt_timer_pkg::*;

  logic [1:0]       rst_q;
  logic             rst_i;
  logic             tick;
  logic [CNT_W-1:0] cnt, cmp;
  logic [CTL_W-1:0] ctl;
  logic             flag_m, flag_o;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  cmt_tick_gen #(.STAGES(3), .STEP(2), .SEL_W(2)) u_tick (
    .clk    (clk),
    .rst_n  (rst_i),
    .wclk   (wclk),
    .clk_sel(clk_sel),
    .pmode  (pmode),
    .tick   (tick)
  );

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_i),
    .tick  (tick),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .cnt   (cnt),
    .cmp   (cmp),
    .ctl   (ctl),
    .flag_m(flag_m),
    .flag_o(flag_o)
  );

  always_comb begin
    case (addr)
      A_CNT:   rdata = cnt;
      A_CMP:   rdata = cmp;
      A_CTL:   rdata = {{(CNT_W-CTL_W){1'b0}}, ctl};
      default: rdata = {{(CNT_W-2){1'b0}}, flag_o, flag_m};
    endcase
  end

  assign irq_match = flag_m & ctl[CTL_MIE];
  assign irq_ovf   = flag_o & ctl[CTL_OIE];
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             we,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [2:0]       pmode,
  input logic [1:0]       clk_sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             clr_en,
  input logic             flag_m,
  input logic             flag_o
);
  import cmt_timer_pkg::*;
  logic cw, hit;
  assign cw  = we && (addr == A_CNT);
  assign hit = (cnt == cmp);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cw) |=> $stable(cnt)); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && !(hit && clr_en)) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && (&cnt)) |=> (flag_o && cnt == '0)); // R3
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && hit) |=> flag_m); // R4
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && hit && clr_en) |=> (cnt == '0)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (cnt == $past(wdata))); // R6
  AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !flag_m) |=> !flag_m); // R6
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_m && !(we && addr == A_STS && !wdata[STS_M])) |=> flag_m); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(we && addr == A_STS && !wdata[STS_O])) |=> flag_o); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode >= PM_STBY && !cw) |=> $stable(cnt)); // R10
  AST_SUB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode >= PM_SUBACT && pmode <= PM_WATCH && clk_sel != 2'd3 && !cw) |=> $stable(cnt)); // R10
endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_i),
  .tick   (tick),
  .we     (we),
  .addr   (addr),
  .wdata  (wdata),
  .pmode  (pmode),
  .clk_sel(clk_sel),
  .cnt    (cnt),
  .cmp    (cmp),
  .clr_en (ctl[0]),
  .flag_m (flag_m),
  .flag_o (flag_o)
);

// File: tb/sim_cmt_timer.sv
`timescale 1ns/1ps
module sim_cmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WHALF      = 6;

  logic        clk = 1'b0;
  logic        rst_n, wclk, we;
  logic [1:0]  clk_sel, addr;
  logic [2:0]  pmode;
  logic [15:0] wdata, rdata;
  logic        irq_match, irq_ovf;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  cmt_timer u0 (.clk(clk), .rst_n(rst_n), .wclk(wclk), .clk_sel(clk_sel), .pmode(pmode),
                .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
                .irq_match(irq_match), .irq_ovf(irq_ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  // watch clock: toggles every WHALF system-clock cycles, changed at negedge
  initial begin
    wclk = 1'b0;
    forever begin
      repeat (WHALF) @(negedge clk);
      wclk = ~wclk;
    end
  end

  // reference model built from the requirements
  logic        m_r1 = 0, m_r2 = 0;
  logic [5:0]  m_pre;
  logic [2:0]  m_s;
  logic [1:0]  m_wdiv;
  logic [15:0] m_cnt, m_cmp;
  logic [2:0]  m_ctl;
  logic        m_fm, m_fo;

  function automatic logic run_ok(input logic [2:0] pm, input logic [1:0] sel);
    if (pm <= 3'd1) return 1'b1;
    if (pm <= 3'd4) return sel == 2'd3;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic rise, src, tk, cw, mev, oev;
    if (!m_r2) begin
      m_pre = '0; m_s = '0; m_wdiv = '0;
      m_cnt = 16'h0000; m_cmp = 16'hFFFF; m_ctl = '0; m_fm = 0; m_fo = 0;
    end else begin
      rise = m_s[1] & ~m_s[2];
      case (clk_sel)
        2'd0:    src = &m_pre[1:0];
        2'd1:    src = &m_pre[3:0];
        2'd2:    src = &m_pre;
        default: src = rise && (m_wdiv == 2'd3);
      endcase
      tk  = src && run_ok(pmode, clk_sel);
      cw  = we && addr == 2'd0;
      mev = tk && !cw && (m_cnt == m_cmp);
      oev = tk && !cw && (m_cnt == 16'hFFFF);
      m_pre = m_pre + 6'd1;
      m_s   = {m_s[1:0], wclk};
      if (rise) m_wdiv = m_wdiv + 2'd1;
      if (cw) m_cnt = wdata;
      else if (tk) m_cnt = (mev && m_ctl[0]) ? 16'h0000 : m_cnt + 16'd1;
      if (we && addr == 2'd1) m_cmp = wdata;
      if (we && addr == 2'd2) m_ctl = wdata[2:0];
      if (mev) m_fm = 1'b1; else if (we && addr == 2'd3 && !wdata[0]) m_fm = 1'b0;
      if (oev) m_fo = 1'b1; else if (we && addr == 2'd3 && !wdata[1]) m_fo = 1'b0;
    end
    m_r2 <= m_r1;
    m_r1 <= rst_n;
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return m_cmp;
      2'd2:    return {13'd0, m_ctl};
      default: return {14'd0, m_fo, m_fm};
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk(tag, rdata, exp_rd(addr));
    chk("R8", {15'd0, irq_match}, {15'd0, m_fm & m_ctl[1]});
    chk("R8", {15'd0, irq_ovf},   {15'd0, m_fo & m_ctl[2]});
  endtask

  // drive one cycle (called just after a negedge), then check after the edge
  task automatic go(input logic w, input logic [1:0] a, input logic [15:0] d);
    we = w; addr = a; wdata = d;
    @(negedge clk);
    chk_all();
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    go(1'b0, a, 16'h0);
    v = rdata;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) go(1'b0, a, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, v0;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; we = 0; addr = 0; wdata = 0; clk_sel = 0; pmode = 3'd5;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset values, counter frozen in standby
    tag = "R1";
    rd(2'd0, v); chk("R1", v, 16'h0000);
    rd(2'd1, v); chk("R1", v, 16'hFFFF);
    rd(2'd2, v); chk("R1", v, 16'h0000);
    rd(2'd3, v); chk("R1", v, 16'h0000);
    chk("R1", {14'd0, irq_match, irq_ovf}, 16'h0);

    // R2: rates of the internal sources
    tag = "R2"; pmode = 3'd0; clk_sel = 2'd0;
    go(1'b1, 2'd0, 16'h0000);
    rd(2'd0, v0); idle(63, 2'd0); rd(2'd0, v);
    chk("R2", v - v0, 16'd16);
    clk_sel = 2'd1;
    rd(2'd0, v0); idle(63, 2'd0); rd(2'd0, v);
    chk("R2", v - v0, 16'd4);
    clk_sel = 2'd2;
    rd(2'd0, v0); idle(127, 2'd0); rd(2'd0, v);
    chk("R2", v - v0, 16'd2);

    // R3: wrap and overflow flag
    tag = "R3"; clk_sel = 2'd0;
    go(1'b1, 2'd1, 16'h1234);
    go(1'b1, 2'd0, 16'hFFFD);
    idle(24, 2'd3);
    rd(2'd3, v); chk("R3", v & 16'h2, 16'h2);
    rd(2'd0, v); chk("R3", {15'd0, v < 16'd8}, 16'd1);

    // R4: match flag only on leaving the equal value
    tag = "R4"; pmode = 3'd5;
    go(1'b1, 2'd3, 16'h0000);
    go(1'b1, 2'd1, 16'h0040);
    go(1'b1, 2'd0, 16'h0040);
    idle(8, 2'd3);
    rd(2'd3, v); chk("R4", v & 16'h1, 16'h0);
    pmode = 3'd0;
    idle(10, 2'd0);
    rd(2'd3, v); chk("R4", v & 16'h1, 16'h1);
    rd(2'd0, v); chk("R4", {15'd0, v > 16'h0040}, 16'd1);

    // R5: clear-on-match keeps the counter in 0..cmp
    tag = "R5";
    go(1'b1, 2'd2, 16'h0001);
    go(1'b1, 2'd1, 16'h0005);
    go(1'b1, 2'd0, 16'h0000);
    for (int i = 0; i < 60; i++) begin
      rd(2'd0, v); chk("R5", {15'd0, v <= 16'd5}, 16'd1);
    end

    // R6: continuous loads of the compare value never set the flag
    tag = "R6";
    go(1'b1, 2'd2, 16'h0000);
    go(1'b1, 2'd3, 16'h0000);
    for (int i = 0; i < 24; i++) go(1'b1, 2'd0, 16'h0005);
    pmode = 3'd5;
    rd(2'd3, v); chk("R6", v & 16'h1, 16'h0);
    rd(2'd0, v); chk("R6", v, 16'h0005);

    // R7: writing 1 keeps, writing 0 clears
    tag = "R7"; pmode = 3'd0;
    go(1'b1, 2'd0, 16'hFFFE);
    go(1'b1, 2'd1, 16'hFFFE);
    idle(20, 2'd3);
    pmode = 3'd5;
    rd(2'd3, v); chk("R7", v, 16'h0003);
    go(1'b1, 2'd3, 16'h0003);
    rd(2'd3, v); chk("R7", v, 16'h0003);
    go(1'b1, 2'd3, 16'h0002);
    rd(2'd3, v); chk("R7", v, 16'h0002);
    go(1'b1, 2'd3, 16'h0000);
    rd(2'd3, v); chk("R7", v, 16'h0000);

    // R8: interrupt gating
    tag = "R8";
    go(1'b1, 2'd0, 16'hFFFF);
    go(1'b1, 2'd2, 16'h0006);
    pmode = 3'd0;
    idle(12, 2'd3);
    chk("R8", {15'd0, irq_ovf}, 16'd1);
    go(1'b1, 2'd2, 16'h0002);
    chk("R8", {15'd0, irq_ovf}, 16'd0);

    // R9: watch clock source in the watch state, ~one tick per 4 wclk periods
    tag = "R9"; clk_sel = 2'd3; pmode = 3'd4;
    go(1'b1, 2'd1, 16'h8000);
    go(1'b1, 2'd0, 16'h0000);
    idle(4 * 2 * WHALF * 8, 2'd0);
    rd(2'd0, v); chk("R9", {15'd0, (v >= 16'd7) && (v <= 16'd8)}, 16'd1);

    // R10: every power state with every source
    tag = "R10";
    for (int pm = 0; pm < 8; pm++) begin
      for (int s = 0; s < 4; s++) begin
        pmode = 3'(pm); clk_sel = 2'(s);
        rd(2'd0, v0); idle(100, 2'd0); rd(2'd0, v);
        if (pm >= 5 || (pm >= 2 && s != 3)) chk("R10", v, v0);
        else chk("R10", {15'd0, v != v0}, 16'd1);
      end
    end

    // R11: constrained random mix
    tag = "R11";
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] a; logic w; logic [15:0] d; logic [15:0] exp_c;
      if ((i % 200) == 0) begin
        clk_sel = 2'($urandom_range(0, 3));
        pmode   = 3'($urandom_range(0, 7));
        if (pmode > 3'd4 && $urandom_range(0, 1) == 1) pmode = 3'd0;
      end
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 7) == 0);
      exp_c = m_cnt + 16'($urandom_range(0, 3));
      case (a)
        2'd0:    d = ($urandom_range(0, 1) == 1) ? 16'hFFFC : m_cmp;
        2'd1:    d = exp_c;
        2'd2:    d = 16'($urandom_range(0, 7));
        default: d = 16'($urandom_range(0, 3));
      endcase
      go(w, a, d);
    end

    finish_run();
  end
endmodule